// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the word address for a synchronous SRAM array that runs short bursts. On a load cycle it captures the full external address and the read/write type of the access. On each advance cycle that follows, it steps the low address bits to the next beat of a four-beat group. The step order is either a plain modulo count or an XOR of the starting bits with the beat number, chosen by a static order input. The upper address bits never change inside a burst. Advance cycles ignore the select and write inputs, so the access type stays fixed for the whole burst.

The block sits in front of the array. Its outputs are the current full address, the latched access type, the beat index and a valid flag. A low clock enable freezes every register, which stretches the current cycle. Loading while not selected ends the access, and advance cycles that follow it do not start a new one. The order can be fixed at build time through a parameter or left to the order pin.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising edge with `cke`=1, `adv`=0 and `sel`=1, the registers are updated so that from that edge on `addr_out` equals `addr_in`, `beat_out` is 0, `valid_out` is 1 and `wr_out` equals `wr_in`.
- R2: When `order_ilv`=0 (linear order), the low two address bits at beat k are (start + k) mod 4, where start is the low two bits that were loaded.
- R3: When `order_ilv`=1 (interleaved order), the low two address bits at beat k are start XOR k.
- R4: The address bits above bit 1 keep their loaded value across every advance and stall cycle.
- R5: Each edge with `cke`=1 and `adv`=1 raises `beat_out` by one modulo 4. After beat 3 the sequence starts again at beat 0 and repeats the same address pattern indefinitely.
- R6: On advance edges, `sel` and `wr_in` have no effect on any output.
- R7: `wr_out` keeps the value captured at the last selected load for every beat of the burst.
- R8: On an edge with `cke`=0, `addr_out`, `beat_out`, `wr_out` and `valid_out` all keep their values, whatever the other inputs are.
- R9: On an edge with `cke`=1, `adv`=0 and `sel`=0 (deselect), `valid_out` becomes 0 and `beat_out` becomes 0. Later advance edges leave `valid_out` at 0 until the next selected load.
- R10: While `rst_n` is low, and after it is released until the first enabled edge, `addr_out`, `beat_out`, `wr_out` and `valid_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable; 0 stalls the sequencer |
| adv | input | 1 | 1 = advance burst, 0 = load (or deselect) |
| sel | input | 1 | Qualified chip select, sampled only on load cycles |
| wr_in | input | 1 | Access type on load: 1 = write, 0 = read |
| order_ilv | input | 1 | Static burst order: 0 = linear, 1 = interleaved |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address |
| beat_out | output | BEAT_W | Beat index within the group |
| wr_out | output | 1 | Latched access type |
| valid_out | output | 1 | An access is active |

## Verification
Every result is due exactly one rising edge after the command that causes it, because `addr_out` is the loaded base register combined through logic with the beat register. The order pin acts on `addr_out` combinationally, with no delay. The bench drives each command on a falling edge and samples all four outputs 1 ns after the next rising edge. This puts each check on the first edge where the new value can appear and well before the next command is applied. The sweep covers both orders, all four start offsets and both access types. Each burst runs six advances so that it wraps, and includes one stall and one deselect followed by advances.

// File: rtl/burst_pkg.sv
package burst_pkg;

   // decoded command for one clock edge
   typedef enum logic [1:0] {
      CMD_HOLD  = 2'd0,
      CMD_LOAD  = 2'd1,
      CMD_DESEL = 2'd2,
      CMD_ADV   = 2'd3
   } burst_cmd_e;

   // build-time choice of burst order
   localparam int ORDER_LINEAR      = 0;
   localparam int ORDER_INTERLEAVED = 1;
   localparam int ORDER_PIN         = 2;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
   import burst_pkg::*;
(
   input  logic       cke,
   input  logic       adv,
   input  logic       sel,
   output burst_cmd_e cmd
);

   always_comb begin
      if (!cke)
         cmd = CMD_HOLD;
      else if (adv)
         cmd = CMD_ADV;
      else if (sel)
         cmd = CMD_LOAD;
      else
         cmd = CMD_DESEL;
   end

endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
   import burst_pkg::*;
#(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  burst_cmd_e        cmd,
   output logic [BEAT_W-1:0] beat
);

   localparam logic [BEAT_W-1:0] STEP = BEAT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat <= '0;
      else begin
         case (cmd)
            CMD_LOAD, CMD_DESEL: beat <= '0;
            CMD_ADV:             beat <= beat + STEP;
            default:             beat <= beat;
         endcase
      end
   end

endmodule

// File: rtl/burst_state_reg.sv
module burst_state_reg
   import burst_pkg::*;
#(
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  burst_cmd_e        cmd,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              wr_in,
   output logic [ADDR_W-1:0] base,
   output logic              wr_q,
   output logic              valid_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base    <= '0;
         wr_q    <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         case (cmd)
            CMD_LOAD: begin
               base    <= addr_in;
               wr_q    <= wr_in;
               valid_q <= 1'b1;
            end
            CMD_DESEL: valid_q <= 1'b0;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/burst_order.sv
module burst_order
   import burst_pkg::*;
#(
   parameter int BEAT_W    = 2,
   parameter int ORDER_CFG = ORDER_PIN
) (
   input  logic [BEAT_W-1:0] start,
   input  logic [BEAT_W-1:0] beat,
   input  logic              ilv,
   output logic [BEAT_W-1:0] low
);

   logic [BEAT_W-1:0] lin_low;
   logic [BEAT_W-1:0] xor_low;

   assign lin_low = start + beat;

   for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
      assign xor_low[b] = start[b] ^ beat[b];
   end

   if (ORDER_CFG == ORDER_LINEAR) begin : g_lin
      logic unused_ilv;
      assign unused_ilv = ilv ^ (^xor_low);
      assign low = lin_low;
   end else if (ORDER_CFG == ORDER_INTERLEAVED) begin : g_ilv
      logic unused_ilv;
      assign unused_ilv = ilv ^ (^lin_low);
      assign low = xor_low;
   end else begin : g_pin
      assign low = ilv ? xor_low : lin_low;
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_pkg::*;
#(
   parameter int ADDR_W    = 18,
   parameter int BEAT_W    = 2,
   parameter int ORDER_CFG = ORDER_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              adv,
   input  logic              sel,
   input  logic              wr_in,
   input  logic              order_ilv,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out,
   output logic [BEAT_W-1:0] beat_out,
   output logic              wr_out,
   output logic              valid_out
);

   localparam int UPPER_W = ADDR_W - BEAT_W;

   if (BEAT_W < 1) begin : g_bad_beat
      $error("burst_addr_seq: BEAT_W must be at least 1");
   end
   if (UPPER_W < 1) begin : g_bad_addr
      $error("burst_addr_seq: ADDR_W must exceed BEAT_W");
   end
   if (ORDER_CFG < ORDER_LINEAR || ORDER_CFG > ORDER_PIN) begin : g_bad_cfg
      $error("burst_addr_seq: ORDER_CFG out of range");
   end

   burst_cmd_e        cmd;
   logic [ADDR_W-1:0] base;
   logic [BEAT_W-1:0] low;

   burst_ctrl u_ctrl (
      .cke (cke),
      .adv (adv),
      .sel (sel),
      .cmd (cmd)
   );

   burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (cmd),
      .beat  (beat_out)
   );

   burst_state_reg #(.ADDR_W(ADDR_W)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .addr_in (addr_in),
      .wr_in   (wr_in),
      .base    (base),
      .wr_q    (wr_out),
      .valid_q (valid_out)
   );

   burst_order #(.BEAT_W(BEAT_W), .ORDER_CFG(ORDER_CFG)) u_order (
      .start (base[BEAT_W-1:0]),
      .beat  (beat_out),
      .ilv   (order_ilv),
      .low   (low)
   );

   assign addr_out = {base[ADDR_W-1:BEAT_W], low};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W = 18,
   parameter int BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              adv,
   input logic              sel,
   input logic              wr_in,
   input logic              order_ilv,
   input logic [ADDR_W-1:0] addr_in,
   input logic [ADDR_W-1:0] addr_out,
   input logic [BEAT_W-1:0] beat_out,
   input logic              wr_out,
   input logic              valid_out
);

   logic [BEAT_W-1:0] beat_inc;
   logic [BEAT_W-1:0] lin_next;
   logic [BEAT_W-1:0] ilv_next;

   assign beat_inc = beat_out + BEAT_W'(1);
   assign lin_next = addr_out[BEAT_W-1:0] + BEAT_W'(1);
   assign ilv_next = addr_out[BEAT_W-1:0] ^ beat_out ^ beat_inc;

   // R1
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !adv && sel) |=> (valid_out && beat_out == '0 &&
                                addr_out == $past(addr_in) && wr_out == $past(wr_in)));

   // R2
   lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && adv && !order_ilv) |=> (order_ilv || addr_out[BEAT_W-1:0] == $past(lin_next)));

   // R3
   ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && adv && order_ilv) |=> (!order_ilv || addr_out[BEAT_W-1:0] == $past(ilv_next)));

   // R4
   upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke || adv) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

   // R5
   beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && adv) |=> beat_out == $past(beat_inc));

   // R7
   type_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && adv) |=> ($stable(wr_out) && $stable(valid_out)));

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ($stable(beat_out) && $stable(wr_out) && $stable(valid_out)));

   // R9
   desel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !adv && !sel) |=> (!valid_out && beat_out == '0));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .adv       (adv),
   .sel       (sel),
   .wr_in     (wr_in),
   .order_ilv (order_ilv),
   .addr_in   (addr_in),
   .addr_out  (addr_out),
   .beat_out  (beat_out),
   .wr_out    (wr_out),
   .valid_out (valid_out)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;

   localparam int AW = 18;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cke = 1'b0;
   logic          adv = 1'b0;
   logic          sel = 1'b0;
   logic          wr_in = 1'b0;
   logic          order_ilv = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;
   logic [BW-1:0] beat_out;
   logic          wr_out;
   logic          valid_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state
   logic [AW-1:0] m_base = '0;
   int            m_beat = 0;
   logic          m_wr = 1'b0;
   logic          m_valid = 1'b0;

   always #2.5 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke       (cke),
      .adv       (adv),
      .sel       (sel),
      .wr_in     (wr_in),
      .order_ilv (order_ilv),
      .addr_in   (addr_in),
      .addr_out  (addr_out),
      .beat_out  (beat_out),
      .wr_out    (wr_out),
      .valid_out (valid_out)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] exp_addr();
      int s;
      int low;
      s = int'(m_base[1:0]);
      low = order_ilv ? (s ^ m_beat) : ((s + m_beat) % 4);
      return {m_base[AW-1:2], 2'(low)};
   endfunction

   // one clock: drive on falling edge, sample 1 ns after the rising edge
   task automatic step(input logic c, input logic a, input logic s,
                       input logic w, input logic [AW-1:0] ad,
                       input string r_lo, input string r_ty);
      logic [AW-1:0] ea;
      @(negedge clk);
      cke = c; adv = a; sel = s; wr_in = w; addr_in = ad;
      @(posedge clk);
      if (c) begin
         if (!a) begin
            if (s) begin
               m_base = ad; m_wr = w; m_valid = 1'b1; m_beat = 0;
            end else begin
               m_valid = 1'b0; m_beat = 0;
            end
         end else
            m_beat = (m_beat + 1) % 4;
      end
      #1;
      ea = exp_addr();
      chk(beat_out == 2'(m_beat), "R5", "beat index", 32'(beat_out), 32'(m_beat));
      chk(valid_out == m_valid, r_ty, "valid flag", 32'(valid_out), 32'(m_valid));
      chk(wr_out == m_wr, r_ty, "access type", 32'(wr_out), 32'(m_wr));
      if (m_valid) begin
         chk(addr_out[1:0] == ea[1:0], r_lo, "low address bits", 32'(addr_out[1:0]), 32'(ea[1:0]));
         chk(addr_out[AW-1:2] == ea[AW-1:2], "R4", "upper address bits",
             32'(addr_out[AW-1:2]), 32'(ea[AW-1:2]));
      end
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      string r_lo;
      logic [AW-1:0] up;
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      chk(addr_out == '0, "R10", "reset address", 32'(addr_out), 0);
      chk(beat_out == '0, "R10", "reset beat", 32'(beat_out), 0);
      chk(wr_out == 1'b0, "R10", "reset type", 32'(wr_out), 0);
      chk(valid_out == 1'b0, "R10", "reset valid", 32'(valid_out), 0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b1, 1'b1, 18'h3ffff, "R10", "R10");
      chk(addr_out == '0, "R10", "stalled after reset", 32'(addr_out), 0);

      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 2; w++) begin
               @(negedge clk);
               order_ilv = 1'(m);
               r_lo = m ? "R3" : "R2";
               up = AW'((m * 8 + s * 2 + w) * 4421 + 97) << 2;
               // R1 selected load
               step(1'b1, 1'b0, 1'b1, 1'(w), up | AW'(s), r_lo, "R1");
               // R6 advance with select dropped and write input flipped
               step(1'b1, 1'b1, 1'b0, 1'(~w), '1, r_lo, "R6");
               step(1'b1, 1'b1, 1'b1, 1'(~w), '0, r_lo, "R7");
               // R8 stall with a load pattern on the inputs
               step(1'b0, 1'b0, 1'b1, 1'(~w), ~up, r_lo, "R8");
               step(1'b0, 1'b1, 1'b0, 1'(~w), ~up, r_lo, "R8");
               // R5 wrap past the fourth beat
               for (int k = 0; k < 4; k++)
                  step(1'b1, 1'b1, 1'(k & 1), 1'(~w), AW'(k), r_lo, "R7");
               // R9 deselect then advances stay inactive
               step(1'b1, 1'b0, 1'b0, 1'(w), '0, r_lo, "R9");
               step(1'b1, 1'b1, 1'b1, 1'(w), '0, r_lo, "R9");
               step(1'b1, 1'b1, 1'b1, 1'(~w), up, r_lo, "R9");
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule